// File: doc/BRIEF.md
# Channel Command Decoder with Power-Down

This block sits behind the command registers of a two-channel serial controller. A write to the channel A or channel B command register presents a 4-bit command code. The block turns each accepted code into a single-cycle action strobe. The strobe is tagged with the channel that was written. A separate strobe is raised for the code that returns the channel's mode-register pointer to register 0.

The block also owns the power-down state. A power-down command written to channel A turns the oscillator enable off. While the oscillator is off, only the wake-up command on channel A is honoured. After wake-up, a busy flag blocks further commands until the oscillator reports a stable clock for a set number of consecutive cycles. Keeping register contents through power-down and the clock gating cell itself belong to the surrounding design.

Top module: `cmd_decoder_pd`

## Requirements
- R1: After reset, `act_vec` and `mrp_clr_stb` are 0, `osc_en` is 1 and `busy` is 0.
- R2: An accepted write of an action code (1 through 12) raises `act_vec` bit k, where k equals the code. No other bit is raised. The strobe is high in the cycle after the write, and `act_chan` equals the written `wr_chan` (0 = channel A, 1 = channel B).
- R3: An accepted write of code 4'b1011 also raises `mrp_clr_stb` for that same cycle, on either channel.
- R4: Codes 4'b0000 and 4'b1101 produce no strobe.
- R5: Code 4'b1110 written on channel A while running drives `osc_en` low from the next cycle and produces no strobe.
- R6: Codes 4'b1110 and 4'b1111 written on channel B never change `osc_en` or `busy` and produce no strobe.
- R7: While powered down, every write other than 4'b1111 on channel A is discarded. It produces no strobe and `osc_en` stays low.
- R8: Code 4'b1111 on channel A while powered down drives `osc_en` high and `busy` high from the next cycle.
- R9: `busy` falls only after `osc_stable` has been sampled high on STABLE_CYCLES (default 2) consecutive clock edges. A low sample restarts the count.
- R10: Writes made while `busy` is high are dropped. They produce no strobe. Action codes are accepted again once `busy` is low.
- R11: Code 4'b1111 written while running produces no strobe and leaves `osc_en` high and `busy` low.
- R12: Each accepted write gives a strobe lasting exactly one cycle. Back-to-back writes give one strobe per cycle, each with its own channel tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Command register write strobe |
| wr_chan | input | 1 | Written register: 0 = channel A, 1 = channel B |
| wr_cmd | input | 4 | Command code |
| osc_stable | input | 1 | Oscillator reports a stable clock |
| act_vec | output | 16 | One-hot action strobe, bit index = command code |
| act_chan | output | 1 | Channel tag of the current strobe |
| mrp_clr_stb | output | 1 | Strobe: reset mode-register pointer to register 0 |
| osc_en | output | 1 | Oscillator enable, low while powered down |
| busy | output | 1 | High while waiting for the oscillator after wake-up |

## Verification
The assertions assume that `wr_en`, `wr_chan` and `wr_cmd` are stable around each rising edge and free of unknown values. They also assume that `osc_stable` is a clean level already synchronised to `clk`. The bench drives every input on the falling edge and holds `wr_en` for exactly one cycle per write. It lowers `osc_stable` before power-down and raises it deliberately during wake-up, so the stability count is exercised with both an interrupted run and an unbroken one.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int CODE_W    = 4;
  localparam int NUM_CODES = 1 << CODE_W;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CMD_NULL    = 4'b0000;
  localparam code_t CMD_MRP_CLR = 4'b1011;
  localparam code_t CMD_UNUSED  = 4'b1101;
  localparam code_t CMD_PD_ON   = 4'b1110;
  localparam code_t CMD_PD_OFF  = 4'b1111;

  typedef enum logic [1:0] {PWR_RUN = 2'd0, PWR_DOWN = 2'd1, PWR_WAKE = 2'd2} pwr_t;

  // True for codes that map onto an action strobe.
  function automatic logic is_action(input code_t c);
    return !(c == CMD_NULL || c == CMD_UNUSED || c == CMD_PD_ON || c == CMD_PD_OFF);
  endfunction

  // One-hot strobe pattern for a code, empty for non-action codes.
  function automatic logic [NUM_CODES-1:0] code_onehot(input code_t c);
    logic [NUM_CODES-1:0] v;
    v = '0;
    if (is_action(c)) v[c] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/cmd_gate.sv
module cmd_gate
  import cmd_dec_pkg::*;
(
  input  logic  wr_en,
  input  logic  wr_chan,
  input  code_t wr_cmd,
  input  pwr_t  pwr_state,
  output logic  take_action,
  output logic  pd_enter,
  output logic  pd_exit
);
  logic running;
  logic on_chan_a;

  assign running   = (pwr_state == PWR_RUN);
  assign on_chan_a = !wr_chan;

  always_comb begin
    take_action = wr_en && running && is_action(wr_cmd);
    pd_enter    = wr_en && running && on_chan_a && (wr_cmd == CMD_PD_ON);
    pd_exit     = wr_en && (pwr_state == PWR_DOWN) && on_chan_a && (wr_cmd == CMD_PD_OFF);
  end
endmodule

// File: rtl/pwr_ctrl.sv
module pwr_ctrl
  import cmd_dec_pkg::*;
#(
  parameter int STABLE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_enter,
  input  logic pd_exit,
  input  logic osc_stable,
  output pwr_t pwr_state,
  output logic osc_en,
  output logic busy
);
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

  pwr_t             state_q;
  logic [CNT_W-1:0] stable_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= PWR_RUN;
      stable_cnt_q <= '0;
    end else begin
      case (state_q)
        PWR_RUN: begin
          stable_cnt_q <= '0;
          if (pd_enter) state_q <= PWR_DOWN;
        end
        PWR_DOWN: begin
          stable_cnt_q <= '0;
          if (pd_exit) state_q <= PWR_WAKE;
        end
        PWR_WAKE: begin
          if (!osc_stable) begin
            stable_cnt_q <= '0;
          end else if (stable_cnt_q == CNT_LAST) begin
            stable_cnt_q <= '0;
            state_q      <= PWR_RUN;
          end else begin
            stable_cnt_q <= stable_cnt_q + 1'b1;
          end
        end
        default: begin
          state_q      <= PWR_RUN;
          stable_cnt_q <= '0;
        end
      endcase
    end
  end

  assign pwr_state = state_q;
  assign osc_en    = (state_q != PWR_DOWN);
  assign busy      = (state_q == PWR_WAKE);
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import cmd_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take_action,
  input  logic                 wr_chan,
  input  code_t                wr_cmd,
  output logic [NUM_CODES-1:0] act_vec,
  output logic                 act_chan,
  output logic                 mrp_clr_stb
);
  logic [NUM_CODES-1:0] code_hit;
  logic [NUM_CODES-1:0] vec_q;
  logic                 chan_q;
  logic                 mrp_q;

  assign code_hit = code_onehot(wr_cmd);

  for (genvar k = 0; k < NUM_CODES; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vec_q[k] <= 1'b0;
      else        vec_q[k] <= take_action && code_hit[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= 1'b0;
      mrp_q  <= 1'b0;
    end else begin
      mrp_q <= take_action && (wr_cmd == CMD_MRP_CLR);
      if (take_action) chan_q <= wr_chan;
    end
  end

  assign act_vec     = vec_q;
  assign act_chan    = chan_q;
  assign mrp_clr_stb = mrp_q;
endmodule

// File: rtl/cmd_decoder_pd.sv
module cmd_decoder_pd
  import cmd_dec_pkg::*;
#(
  parameter int STABLE_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_chan,
  input  logic [3:0]  wr_cmd,
  input  logic        osc_stable,
  output logic [15:0] act_vec,
  output logic        act_chan,
  output logic        mrp_clr_stb,
  output logic        osc_en,
  output logic        busy
);
  pwr_t pwr_state;
  logic take_action;
  logic pd_enter;
  logic pd_exit;

  cmd_gate u_gate (
    .wr_en       (wr_en),
    .wr_chan     (wr_chan),
    .wr_cmd      (wr_cmd),
    .pwr_state   (pwr_state),
    .take_action (take_action),
    .pd_enter    (pd_enter),
    .pd_exit     (pd_exit)
  );

  pwr_ctrl #(.STABLE_CYCLES(STABLE_CYCLES)) u_pwr (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_enter   (pd_enter),
    .pd_exit    (pd_exit),
    .osc_stable (osc_stable),
    .pwr_state  (pwr_state),
    .osc_en     (osc_en),
    .busy       (busy)
  );

  strobe_gen u_stb (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_action (take_action),
    .wr_chan     (wr_chan),
    .wr_cmd      (wr_cmd),
    .act_vec     (act_vec),
    .act_chan    (act_chan),
    .mrp_clr_stb (mrp_clr_stb)
  );
endmodule

// File: rtl/cmd_decoder_pd_chk.sv
module cmd_decoder_pd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_chan,
  input logic [3:0]  wr_cmd,
  input logic        osc_stable,
  input logic [15:0] act_vec,
  input logic        act_chan,
  input logic        mrp_clr_stb,
  input logic        osc_en,
  input logic        busy,
  input logic        take_action
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_vec)); // R2

  AST_STROBE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    take_action |=> (act_chan == $past(wr_chan)) && $countones(act_vec) == 1); // R2

  AST_MRP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    mrp_clr_stb |-> $past(wr_en) && ($past(wr_cmd) == 4'b1011) && act_vec[11]); // R3

  AST_UNUSED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_cmd == 4'b1101 || wr_cmd == 4'b0000)) |=> (act_vec == '0) && !mrp_clr_stb); // R4

  AST_CHAN_B_NO_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_chan && wr_cmd[3:1] == 3'b111) |=> $stable(osc_en) && $stable(busy)); // R6

  AST_DOWN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && wr_en) |=> (act_vec == '0)); // R7

  AST_WAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> busy); // R8

  AST_DOWN_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !busy); // R8

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !osc_stable) |=> busy); // R9

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> (act_vec == '0) && !mrp_clr_stb); // R10

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|act_vec) |-> $past(take_action)); // R12
endmodule

bind cmd_decoder_pd cmd_decoder_pd_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_chan     (wr_chan),
  .wr_cmd      (wr_cmd),
  .osc_stable  (osc_stable),
  .act_vec     (act_vec),
  .act_chan    (act_chan),
  .mrp_clr_stb (mrp_clr_stb),
  .osc_en      (osc_en),
  .busy        (busy),
  .take_action (take_action)
);

// File: tb/cmd_decoder_pd_test.sv
`timescale 1ns/1ps
module cmd_decoder_pd_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_chan = 1'b0;
  logic [3:0]  wr_cmd = 4'd0;
  logic        osc_stable = 1'b1;
  logic [15:0] act_vec;
  logic        act_chan;
  logic        mrp_clr_stb;
  logic        osc_en;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmd_decoder_pd uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_cmd(wr_cmd),
    .osc_stable(osc_stable), .act_vec(act_vec), .act_chan(act_chan),
    .mrp_clr_stb(mrp_clr_stb), .osc_en(osc_en), .busy(busy)
  );

  function automatic logic [15:0] model_vec(input logic [3:0] c);
    if (c >= 4'd1 && c <= 4'd12) return 16'(1) << c;
    return 16'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic ch, input logic [3:0] c);
    wr_en = 1'b1; wr_chan = ch; wr_cmd = c;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 act_vec", 32'(act_vec), 0);
    check("R1 mrp", 32'(mrp_clr_stb), 0);
    check("R1 osc_en", 32'(osc_en), 1);
    check("R1 busy", 32'(busy), 0);
  endtask

  task automatic t_actions();
    for (int c = 0; c < 14; c++) begin
      logic ch;
      ch = 1'(c % 2);
      wr(ch, 4'(c));
      check((c == 0 || c == 13) ? "R4 silent code" : "R2 strobe", 32'(act_vec), 32'(model_vec(4'(c))));
      check("R3 mrp strobe", 32'(mrp_clr_stb), (c == 11) ? 1 : 0);
      if (model_vec(4'(c)) != 0) check("R2 channel tag", 32'(act_chan), 32'(ch));
      tick();
      check("R12 one cycle", 32'(act_vec), 0);
    end
  endtask

  task automatic t_back2back();
    wr_en = 1'b1; wr_chan = 1'b0; wr_cmd = 4'd3;
    tick();
    check("R12 first", 32'(act_vec), 32'h8);
    check("R12 first tag", 32'(act_chan), 0);
    wr_chan = 1'b1; wr_cmd = 4'd7;
    tick();
    wr_en = 1'b0;
    check("R12 second", 32'(act_vec), 32'h80);
    check("R12 second tag", 32'(act_chan), 1);
    tick();
    check("R12 gap", 32'(act_vec), 0);
  endtask

  task automatic t_run_pd_cmds();
    wr(1'b1, 4'b1110);
    check("R6 osc_en", 32'(osc_en), 1);
    check("R6 strobe", 32'(act_vec), 0);
    wr(1'b0, 4'b1111);
    check("R11 osc_en", 32'(osc_en), 1);
    check("R11 busy", 32'(busy), 0);
    check("R11 strobe", 32'(act_vec), 0);
  endtask

  task automatic t_power_down();
    osc_stable = 1'b0;
    wr(1'b0, 4'b1110);
    check("R5 osc_en", 32'(osc_en), 0);
    check("R5 strobe", 32'(act_vec), 0);
    wr(1'b0, 4'd1);
    check("R7 strobe code1", 32'(act_vec), 0);
    wr(1'b0, 4'b1011);
    check("R7 mrp", 32'(mrp_clr_stb), 0);
    wr(1'b0, 4'b1110);
    check("R7 osc_en", 32'(osc_en), 0);
    wr(1'b1, 4'b1111);
    check("R6 chan B exit", 32'(osc_en), 0);
    check("R6 busy", 32'(busy), 0);
  endtask

  task automatic t_wake();
    wr(1'b0, 4'b1111);
    check("R8 osc_en", 32'(osc_en), 1);
    check("R8 busy", 32'(busy), 1);
    wr(1'b1, 4'd5);
    check("R10 dropped", 32'(act_vec), 0);
    check("R10 busy", 32'(busy), 1);
    osc_stable = 1'b1; tick();
    check("R9 one sample", 32'(busy), 1);
    osc_stable = 1'b0; tick();
    check("R9 restart", 32'(busy), 1);
    osc_stable = 1'b1; tick();
    check("R9 first of two", 32'(busy), 1);
    tick();
    check("R9 released", 32'(busy), 0);
    wr(1'b1, 4'd5);
    check("R10 accepted again", 32'(act_vec), 32'h20);
    check("R10 tag", 32'(act_chan), 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_actions();
    t_back2back();
    t_run_pd_cmds();
    t_power_down();
    t_wake();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule